// File: doc/BRIEF.md
# Dual-Clock Watchdog with Sleep Wake-Up

This block is a watchdog timer whose counter runs from a dedicated watchdog oscillator instead of the system clock. Because of that, it keeps counting after the system clock has been stopped for a low-power sleep. Software keeps the watchdog quiet by sending a clear strobe in the system clock domain. The strobe is carried into the watchdog domain and restarts the count from zero.

When the count reaches its terminal value, the result depends on the power state. If the system is awake, a reset request goes back to the system domain and is stretched over a fixed number of system clocks. If the system is asleep, the watchdog-domain logic raises a wake request directly. No system clock is needed for this, so the wake-up logic can restart the clock, and execution continues without a reset. A status flag in the system domain records that the watchdog caused the most recent reset or wake-up. A clear strobe removes it.

Top module: `sleep_wake_watchdog`

## Requirements
- R1: While `rst` is held and for as long as nothing has timed out after it, `reset_req`, `wake_req` and `wdt_flag` are all 0.
- R2: While `wdt_en` is 0 the watchdog count stays at zero and no timeout occurs, however long it remains low.
- R3: With `wdt_en` at 1, a timeout fires after `TERM_COUNT`+1 watchdog clocks of counting from zero. The count never goes above `TERM_COUNT`, and it restarts from zero after each timeout.
- R4: A one-cycle `wdt_clear` pulse (system domain) restarts the count at zero in the watchdog domain. Clears that come more often than the timeout period prevent any timeout.
- R5: A timeout while `sleep_mode` is 0 drives `reset_req` to 1 for exactly `RST_HOLD` consecutive system clocks. `RST_HOLD` must be at least 2.
- R6: A timeout while `sleep_mode` is 1 sets `wake_req`, which is registered on `wd_clk`. This works with the system clock stopped, and that timeout produces no `reset_req` pulse.
- R7: Once set, `wake_req` stays at 1 while `sleep_mode` remains 1. It returns to 0 a few watchdog clocks after `sleep_mode` falls.
- R8: `wdt_flag` becomes 1 on the same system clock edge on which a watchdog `reset_req` pulse starts, or after a watchdog wake-up is seen in the system domain. A `wdt_clear` pulse returns it to 0.

Top module ports are listed below; `wdt_en`, `wdt_clear` and `sleep_mode` belong to the system domain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock; may be stopped while asleep |
| wd_clk | input | 1 | Free-running watchdog oscillator clock |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| wdt_en | input | 1 | Watchdog enable (level) |
| wdt_clear | input | 1 | Single-cycle clear strobe that restarts the count and clears the flag |
| sleep_mode | input | 1 | 1 while the system is in sleep |
| reset_req | output | 1 | Stretched device reset request, system domain |
| wake_req | output | 1 | Wake-up request, watchdog domain |
| wdt_flag | output | 1 | Last reset or wake-up came from the watchdog |

## Verification
The hardest situation to reach is a timeout during sleep with the system clock actually stopped. The wake request then has to appear with no system-domain logic running, and the flag must be set only after the clock comes back. To get there, the bench gates its own system clock. It raises `sleep_mode`, stops the clock while it is low, and waits a counted number of watchdog cycles: first to confirm there is no early wake, then to see the wake request. It then restarts the clock, checks the flag and the absence of any reset pulse, and releases sleep to see the wake request drop.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Events travelling from the watchdog domain to the system domain.
  typedef struct packed {
    logic rst_tgl; // flips once per awake timeout
    logic wake;    // level wake request
  } wd_evt_t;

  // Controls travelling from the system domain to the watchdog domain.
  typedef struct packed {
    logic en;
    logic sleep;
    logic clr_tgl; // flips once per clear strobe
  } sys_ctl_t;

  localparam int unsigned EVT_W = $bits(wd_evt_t);
  localparam int unsigned CTL_W = $bits(sys_ctl_t);
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/wdt_wd_core.sv
module wdt_wd_core
  import wdt_pkg::*;
#(
  parameter int unsigned      CNT_W      = 16,
  parameter logic [CNT_W-1:0] TERM_COUNT = '1
) (
  input  logic             wd_clk,
  input  logic             rst,
  input  sys_ctl_t         ctl_s,
  output wd_evt_t          evt,
  output logic [CNT_W-1:0] count,
  output logic             en_seen,
  output logic             sleep_seen
);
  logic [CNT_W-1:0] count_q;
  logic             clr_d_q;
  logic             rst_tgl_q;
  logic             wake_q;
  logic             clr_p;
  logic             at_term;
  logic             tmo;

  assign clr_p   = ctl_s.clr_tgl ^ clr_d_q;
  assign at_term = (count_q == TERM_COUNT);
  assign tmo     = ctl_s.en && !clr_p && at_term;

  always_ff @(posedge wd_clk) begin
    if (rst) begin
      clr_d_q <= 1'b0;
    end else begin
      clr_d_q <= ctl_s.clr_tgl;
    end
  end

  always_ff @(posedge wd_clk) begin
    if (rst || !ctl_s.en || clr_p || at_term) begin
      count_q <= '0;
    end else begin
      count_q <= count_q + 1'b1;
    end
  end

  always_ff @(posedge wd_clk) begin
    if (rst) begin
      rst_tgl_q <= 1'b0;
      wake_q    <= 1'b0;
    end else begin
      if (tmo && !ctl_s.sleep) begin
        rst_tgl_q <= ~rst_tgl_q;
      end
      if (tmo && ctl_s.sleep) begin
        wake_q <= 1'b1;
      end else if (!ctl_s.sleep) begin
        wake_q <= 1'b0;
      end
    end
  end

  assign evt.rst_tgl = rst_tgl_q;
  assign evt.wake    = wake_q;
  assign count       = count_q;
  assign en_seen     = ctl_s.en;
  assign sleep_seen  = ctl_s.sleep;
endmodule

// File: rtl/wdt_sys_ctrl.sv
module wdt_sys_ctrl
  import wdt_pkg::*;
#(
  parameter int unsigned RST_HOLD = 2
) (
  input  logic    sys_clk,
  input  logic    rst,
  input  logic    clear,
  input  wd_evt_t evt_s,
  output logic    clr_tgl,
  output logic    reset_req,
  output logic    flag
);
  localparam int unsigned HW = $clog2(RST_HOLD + 1);

  logic          clr_tgl_q;
  logic          rst_tgl_d_q;
  logic          wake_d_q;
  logic [HW-1:0] hold_q;
  logic [HW-1:0] hold_n;
  logic          req_q;
  logic          flag_q;
  logic          rst_evt;
  logic          wake_rise;

  assign rst_evt   = evt_s.rst_tgl ^ rst_tgl_d_q;
  assign wake_rise = evt_s.wake && !wake_d_q;

  always_comb begin
    if (rst_evt) begin
      hold_n = HW'(RST_HOLD);
    end else if (hold_q != '0) begin
      hold_n = hold_q - HW'(1);
    end else begin
      hold_n = '0;
    end
  end

  always_ff @(posedge sys_clk) begin
    if (rst) begin
      clr_tgl_q   <= 1'b0;
      rst_tgl_d_q <= 1'b0;
      wake_d_q    <= 1'b0;
      hold_q      <= '0;
      req_q       <= 1'b0;
      flag_q      <= 1'b0;
    end else begin
      if (clear) begin
        clr_tgl_q <= ~clr_tgl_q;
      end
      rst_tgl_d_q <= evt_s.rst_tgl;
      wake_d_q    <= evt_s.wake;
      hold_q      <= hold_n;
      req_q       <= (hold_n != '0);
      if (rst_evt || wake_rise) begin
        flag_q <= 1'b1;
      end else if (clear) begin
        flag_q <= 1'b0;
      end
    end
  end

  assign clr_tgl   = clr_tgl_q;
  assign reset_req = req_q;
  assign flag      = flag_q;
endmodule

// File: rtl/sleep_wake_watchdog.sv
module sleep_wake_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned      CNT_W       = 16,
  parameter logic [CNT_W-1:0] TERM_COUNT  = '1,
  parameter int unsigned      RST_HOLD    = 2,
  parameter int unsigned      SYNC_STAGES = 2
) (
  input  logic sys_clk,
  input  logic wd_clk,
  input  logic rst,
  input  logic wdt_en,
  input  logic wdt_clear,
  input  logic sleep_mode,
  output logic reset_req,
  output logic wake_req,
  output logic wdt_flag
);
  sys_ctl_t         ctl_raw;
  sys_ctl_t         ctl_s;
  wd_evt_t          evt_raw;
  wd_evt_t          evt_s;
  logic             clr_tgl;
  logic [CNT_W-1:0] wd_count;
  logic             wd_en;
  logic             wd_sleep;

  assign ctl_raw.en      = wdt_en;
  assign ctl_raw.sleep   = sleep_mode;
  assign ctl_raw.clr_tgl = clr_tgl;

  wdt_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk (wd_clk),
    .rst (rst),
    .d   (ctl_raw),
    .q   (ctl_s)
  );

  wdt_wd_core #(.CNT_W(CNT_W), .TERM_COUNT(TERM_COUNT)) u_core (
    .wd_clk     (wd_clk),
    .rst        (rst),
    .ctl_s      (ctl_s),
    .evt        (evt_raw),
    .count      (wd_count),
    .en_seen    (wd_en),
    .sleep_seen (wd_sleep)
  );

  wdt_sync #(.W(EVT_W), .STAGES(SYNC_STAGES)) u_evt_sync (
    .clk (sys_clk),
    .rst (rst),
    .d   (evt_raw),
    .q   (evt_s)
  );

  wdt_sys_ctrl #(.RST_HOLD(RST_HOLD)) u_sys (
    .sys_clk   (sys_clk),
    .rst       (rst),
    .clear     (wdt_clear),
    .evt_s     (evt_s),
    .clr_tgl   (clr_tgl),
    .reset_req (reset_req),
    .flag      (wdt_flag)
  );

  assign wake_req = evt_raw.wake;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned      CNT_W      = 16,
  parameter logic [CNT_W-1:0] TERM_COUNT = '1
) (
  input logic             sys_clk,
  input logic             wd_clk,
  input logic             rst,
  input logic             reset_req,
  input logic             wake_req,
  input logic             wdt_flag,
  input logic [CNT_W-1:0] wd_count,
  input logic             wd_en,
  input logic             wd_sleep
);
  AST_RST_HOLD_MIN: assert property (@(posedge sys_clk) disable iff (rst)
    $rose(reset_req) |=> reset_req); // R5

  AST_FLAG_WITH_RST: assert property (@(posedge sys_clk) disable iff (rst)
    $rose(reset_req) |-> wdt_flag); // R8

  AST_CNT_LIMIT: assert property (@(posedge wd_clk) disable iff (rst)
    wd_count <= TERM_COUNT); // R3

  AST_IDLE_WHEN_OFF: assert property (@(posedge wd_clk) disable iff (rst)
    !wd_en |=> (wd_count == '0)); // R2

  AST_WAKE_ONLY_ASLEEP: assert property (@(posedge wd_clk) disable iff (rst)
    $rose(wake_req) |-> $past(wd_sleep)); // R6

  AST_WAKE_HELD: assert property (@(posedge wd_clk) disable iff (rst)
    (wake_req && wd_sleep) |=> wake_req); // R7
endmodule

bind sleep_wake_watchdog wdt_checker #(
  .CNT_W(CNT_W),
  .TERM_COUNT(TERM_COUNT)
) u_wdt_chk (
  .sys_clk   (sys_clk),
  .wd_clk    (wd_clk),
  .rst       (rst),
  .reset_req (reset_req),
  .wake_req  (wake_req),
  .wdt_flag  (wdt_flag),
  .wd_count  (wd_count),
  .wd_en     (wd_en),
  .wd_sleep  (wd_sleep)
);

// File: tb/sleep_wake_watchdog_tb_top.sv
`timescale 1ns/1ps
module sleep_wake_watchdog_tb_top;
  localparam int unsigned      CNT_W = 16;
  localparam logic [CNT_W-1:0] TERM  = 16'd50;
  localparam int unsigned      HOLD  = 3;

  logic sys_clk = 1'b0;
  logic wd_clk  = 1'b0;
  logic sys_run = 1'b1;
  logic rst = 1'b1;
  logic wdt_en = 1'b0;
  logic wdt_clear = 1'b0;
  logic sleep_mode = 1'b0;
  logic reset_req, wake_req, wdt_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always begin
    #10;
    if (sys_run) sys_clk = ~sys_clk;
  end

  always #16.5 wd_clk = ~wd_clk;

  sleep_wake_watchdog #(
    .CNT_W(CNT_W), .TERM_COUNT(TERM), .RST_HOLD(HOLD), .SYNC_STAGES(2)
  ) dut_i (
    .sys_clk(sys_clk), .wd_clk(wd_clk), .rst(rst), .wdt_en(wdt_en),
    .wdt_clear(wdt_clear), .sleep_mode(sleep_mode),
    .reset_req(reset_req), .wake_req(wake_req), .wdt_flag(wdt_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sys_cycles(input int n);
    repeat (n) @(negedge sys_clk);
  endtask

  task automatic pulse_clear();
    @(negedge sys_clk) wdt_clear = 1'b1;
    @(negedge sys_clk) wdt_clear = 1'b0;
  endtask

  task automatic t_reset();
    sys_cycles(2);
    check(reset_req == 1'b0, "R1 reset_req", int'(reset_req), 0);
    check(wake_req == 1'b0,  "R1 wake_req",  int'(wake_req), 0);
    check(wdt_flag == 1'b0,  "R1 wdt_flag",  int'(wdt_flag), 0);
  endtask

  task automatic t_disabled();
    int seen = 0;
    wdt_en = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge sys_clk);
      if (reset_req) seen++;
    end
    check(seen == 0, "R2 no reset while disabled", seen, 0);
    check(wdt_flag == 1'b0, "R2 flag stays clear", int'(wdt_flag), 0);
  endtask

  task automatic t_timeout();
    int n = 0;
    int width = 0;
    @(negedge sys_clk) wdt_en = 1'b1;
    while (!reset_req && n < 300) begin
      @(negedge sys_clk);
      n++;
    end
    // enable sync + 51 watchdog clocks + return sync: about 88..92 system clocks
    check(n >= 86 && n <= 96, "R3 timeout period", n, 90);
    check(wdt_flag == 1'b1, "R8 flag set with reset", int'(wdt_flag), 1);
    while (reset_req && width < 50) begin
      width++;
      @(negedge sys_clk);
    end
    check(width == HOLD, "R5 reset width", width, HOLD);
    check(wake_req == 1'b0, "R6 no wake while awake", int'(wake_req), 0);
    wdt_en = 1'b0;
    sys_cycles(10);
  endtask

  task automatic t_flag_clear();
    check(wdt_flag == 1'b1, "R8 flag kept before clear", int'(wdt_flag), 1);
    pulse_clear();
    sys_cycles(2);
    check(wdt_flag == 1'b0, "R8 flag cleared by strobe", int'(wdt_flag), 0);
  endtask

  task automatic t_kick();
    int seen = 0;
    @(negedge sys_clk) wdt_en = 1'b1;
    for (int k = 0; k < 15; k++) begin
      for (int i = 0; i < 40; i++) begin
        @(negedge sys_clk);
        if (reset_req) seen++;
      end
      pulse_clear();
    end
    check(seen == 0, "R4 periodic clear prevents timeout", seen, 0);
    check(wdt_flag == 1'b0, "R4 flag untouched by kicks", int'(wdt_flag), 0);
    wdt_en = 1'b0;
    sys_cycles(10);
  endtask

  task automatic t_sleep();
    int seen = 0;
    @(negedge sys_clk) wdt_en = 1'b1;
    pulse_clear();
    @(negedge sys_clk) sleep_mode = 1'b1;
    sys_cycles(3);
    check(wdt_flag == 1'b0, "R8 flag clear before sleep", int'(wdt_flag), 0);
    @(negedge sys_clk) sys_run = 1'b0;
    repeat (30) @(posedge wd_clk);
    #5;
    check(wake_req == 1'b0, "R6 no early wake", int'(wake_req), 0);
    repeat (70) @(posedge wd_clk);
    #5;
    check(wake_req == 1'b1, "R6 wake with system clock stopped", int'(wake_req), 1);
    check(reset_req == 1'b0, "R6 no reset during sleep", int'(reset_req), 0);
    sys_run = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge sys_clk);
      if (reset_req) seen++;
    end
    check(wake_req == 1'b1, "R7 wake held while asleep", int'(wake_req), 1);
    check(wdt_flag == 1'b1, "R8 flag set by wake", int'(wdt_flag), 1);
    sleep_mode = 1'b0;
    wdt_en = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge sys_clk);
      if (reset_req) seen++;
    end
    check(seen == 0, "R6 no reset pulse after wake", seen, 0);
    check(wake_req == 1'b0, "R7 wake drops after sleep ends", int'(wake_req), 0);
  endtask

  initial begin
    repeat (6) @(posedge wd_clk);
    @(negedge sys_clk) rst = 1'b0;
    t_reset();
    t_disabled();
    t_timeout();
    t_flag_clear();
    t_kick();
    t_sleep();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule